// File: doc/BRIEF.md
# Fifth-Order Sinc Decimator for a One-Bit Sigma-Delta Stream

This block sits behind a one-bit sigma-delta modulator and turns its bitstream into signed 24-bit samples. The block divides the system clock by six to make the modulator sample strobe. The modulator places a new bit on its data line for each strobe. The block maps each sampled bit to +1 or -1 and feeds it into a chain of five integrators. These run at the modulator rate.

Every 64 modulator samples, the last integrator value moves into a chain of five differencing (comb) stages. This gives a sinc^5 response. Its first notch falls at the output word rate, and the further notches repeat at that same spacing. The comb result is shifted down to 24 bits, and a positive full-scale input is clipped to the largest positive code. The block then presents the result with a one-clock valid pulse, so a word appears once every 384 system clocks.

A settled flag tells downstream logic that the filter memory now holds only real input history. The flag stays low after reset and goes high with the fifth output word.

Top module: `sinc5_decim`

## Requirements
- R1: `mod_stb` is a single-clock pulse that repeats exactly every 6 clocks.
- R2: `mod_bit` is sampled only in a clock cycle where `mod_stb` is high. A 1 counts as +1 and a 0 counts as -1. Values on `mod_bit` in other cycles have no effect on the output words.
- R3: `word_vld` is a single-clock pulse that repeats exactly every 384 clocks, which is 64 modulator samples.
- R4: Take an input that repeats every 64 samples and has k ones per period. Once the filter has settled on it, `word` (two's complement) equals (2k-64)*131072. For example, k=32 gives 0, k=48 gives 0x400000, k=16 gives 0xC00000 and k=1 gives -8126464.
- R5: A stream of all ones is clipped to 0x7FFFFF (8388607) and does not wrap to a negative code.
- R6: A stream of all zeros settles to 0x800000 (-8388608).
- R7: `settled` is low after reset and goes high in the same cycle as the fifth `word_vld` pulse after reset. It then stays high until the next reset.
- R8: While `rst` is high, `word`, `word_vld`, `settled` and `mod_stb` are all zero.
- R9: `word` holds its value between `word_vld` pulses.
- R10: A synchronous reset in the middle of a run clears `word` and `settled`. After the reset, the settling count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_bit | input | 1 | Modulator output bit, sampled on `mod_stb` |
| mod_stb | output | 1 | Modulator sample strobe, clk/6 |
| word | output | 24 | Filtered sample, two's complement |
| word_vld | output | 1 | One-clock pulse marking a new `word` |
| settled | output | 1 | High once five words have followed reset |

## Verification
A faulty integrator or comb register does not clear out of the filter. Because the arithmetic is modular, an error in any accumulator shows up as a lasting offset or a wrong code in every later word. It appears no later than the first word that is checked after settling, which is seven words or about 2700 clocks into a pattern.

A slip in the clock divider or the decimation counter shifts the spacing of `mod_stb` or `word_vld`. That spacing is measured on every pulse, so such a fault shows up within one period.

A wrong clip bound or shift amount changes the steady codes for the all-ones, all-zeros and partial-density patterns. A settle counter that is off by one is caught on the fourth or fifth word after any reset.

// File: rtl/sinc5_pkg.sv
package sinc5_pkg;
  localparam int DEF_ORDER = 5;
  localparam int DEF_DEC   = 64;
  localparam int DEF_DIV   = 6;
  localparam int DEF_OUT_W = 24;

  // growth of order*log2(dec) bits plus sign plus one guard bit for +full scale
  function automatic int acc_width(input int order, input int dec);
    return order * $clog2(dec) + 2;
  endfunction

  // right shift that maps the full-scale magnitude onto the output sign boundary
  function automatic int out_shift(input int order, input int dec, input int out_w);
    return order * $clog2(dec) - (out_w - 1);
  endfunction
endpackage

// File: rtl/sinc_timing.sv
module sinc_timing #(
  parameter int DIV = 6,
  parameter int DEC = 64
) (
  input  logic clk,
  input  logic rst,
  output logic smp_stb,
  output logic dec_stb
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int RW = (DEC > 1) ? $clog2(DEC) : 1;

  logic [DW-1:0] div_q;
  logic [RW-1:0] dec_q;
  logic          wrap;

  assign wrap = (div_q == DW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      dec_q   <= '0;
      smp_stb <= 1'b0;
      dec_stb <= 1'b0;
    end else begin
      div_q   <= wrap ? '0 : div_q + DW'(1);
      smp_stb <= wrap;
      dec_stb <= wrap && (dec_q == RW'(DEC - 1));
      if (wrap) dec_q <= (dec_q == RW'(DEC - 1)) ? '0 : dec_q + RW'(1);
    end
  end

  // R1
  smp_one_clk_chk: assert property (@(posedge clk) disable iff (rst)
    smp_stb |=> !smp_stb);

  // R3
  dec_on_smp_chk: assert property (@(posedge clk) disable iff (rst)
    dec_stb |-> smp_stb);
endmodule

// File: rtl/sinc_integ.sv
module sinc_integ #(
  parameter int ORDER = 5,
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp,
  input  logic                    bit_in,
  output logic signed [ACC_W-1:0] acc_out
);
  logic signed [ACC_W-1:0] acc [ORDER];
  logic signed [ACC_W-1:0] step;
  logic signed [ACC_W-1:0] first_q;

  assign step    = bit_in ? ACC_W'(1) : {ACC_W{1'b1}};
  assign first_q = acc[0];
  assign acc_out = acc[ORDER-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ORDER; i++) acc[i] <= '0;
    end else if (smp) begin
      acc[0] <= acc[0] + step;
      for (int i = 1; i < ORDER; i++) acc[i] <= acc[i] + acc[i-1];
    end
  end

  // R2
  step_pm1_chk: assert property (@(posedge clk) disable iff (rst)
    smp |=> (((first_q - $past(first_q)) == ACC_W'(1)) ||
             ((first_q - $past(first_q)) == {ACC_W{1'b1}})));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !smp |=> $stable(first_q));
endmodule

// File: rtl/sinc_comb.sv
module sinc_comb #(
  parameter int ORDER = 5,
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_vld,
  input  logic signed [ACC_W-1:0] in_data,
  output logic                    out_vld,
  output logic signed [ACC_W-1:0] out_data
);
  logic [ORDER-1:0] vv;

  for (genvar g = 0; g < ORDER; g++) begin : stg
    logic signed [ACC_W-1:0] din;
    logic signed [ACC_W-1:0] dly_q;
    logic signed [ACC_W-1:0] y_q;
    logic                    vin;
    logic                    v_q;

    if (g == 0) begin : head
      assign din = in_data;
      assign vin = in_vld;
    end else begin : tail
      assign din = stg[g-1].y_q;
      assign vin = stg[g-1].v_q;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        dly_q <= '0;
        y_q   <= '0;
        v_q   <= 1'b0;
      end else begin
        v_q <= vin;
        if (vin) begin
          dly_q <= din;
          y_q   <= din - dly_q;
        end
      end
    end

    assign vv[g] = v_q;
  end

  assign out_data = stg[ORDER-1].y_q;
  assign out_vld  = stg[ORDER-1].v_q;

  // R3
  comb_single_flight_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(vv));
endmodule

// File: rtl/sinc_out.sv
module sinc_out #(
  parameter int ACC_W  = 32,
  parameter int OUT_W  = 24,
  parameter int SHIFT  = 7,
  parameter int SETTLE = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_vld,
  input  logic signed [ACC_W-1:0] in_data,
  output logic        [OUT_W-1:0] word_q,
  output logic                    vld_q,
  output logic                    settled_q
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

  logic signed [ACC_W-1:0] shifted;
  logic        [OUT_W-1:0] clip;
  logic        [CW-1:0]    cnt_q;

  assign shifted = in_data >>> SHIFT;

  always_comb begin
    if (shifted > MAXV)      clip = MAXV[OUT_W-1:0];
    else if (shifted < MINV) clip = MINV[OUT_W-1:0];
    else                     clip = shifted[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q    <= '0;
      vld_q     <= 1'b0;
      settled_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      vld_q <= in_vld;
      if (in_vld) begin
        word_q <= clip;
        if (cnt_q != CW'(SETTLE)) cnt_q <= cnt_q + CW'(1);
        if (cnt_q >= CW'(SETTLE - 1)) settled_q <= 1'b1;
      end
    end
  end

  // R3
  word_one_clk_chk: assert property (@(posedge clk) disable iff (rst)
    vld_q |=> !vld_q);

  // R7
  settle_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !$fell(settled_q));

  // R7
  settle_on_word_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(settled_q) |-> vld_q);

  // R9
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vld_q |-> $stable(word_q));
endmodule

// File: rtl/sinc5_decim.sv
module sinc5_decim #(
  parameter int ORDER = sinc5_pkg::DEF_ORDER,
  parameter int DEC   = sinc5_pkg::DEF_DEC,
  parameter int DIV   = sinc5_pkg::DEF_DIV,
  parameter int OUT_W = sinc5_pkg::DEF_OUT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mod_bit,
  output logic             mod_stb,
  output logic [OUT_W-1:0] word,
  output logic             word_vld,
  output logic             settled
);
  localparam int ACC_W = sinc5_pkg::acc_width(ORDER, DEC);
  localparam int SHIFT = sinc5_pkg::out_shift(ORDER, DEC, OUT_W);

  logic                    smp;
  logic                    dec;
  logic signed [ACC_W-1:0] integ_q;
  logic                    comb_vld;
  logic signed [ACC_W-1:0] comb_q;

  sinc_timing #(.DIV(DIV), .DEC(DEC)) u_timing (
    .clk     (clk),
    .rst     (rst),
    .smp_stb (smp),
    .dec_stb (dec)
  );

  sinc_integ #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
    .clk     (clk),
    .rst     (rst),
    .smp     (smp),
    .bit_in  (mod_bit),
    .acc_out (integ_q)
  );

  sinc_comb #(.ORDER(ORDER), .ACC_W(ACC_W)) u_comb (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (dec),
    .in_data  (integ_q),
    .out_vld  (comb_vld),
    .out_data (comb_q)
  );

  sinc_out #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT(SHIFT), .SETTLE(ORDER)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (comb_vld),
    .in_data   (comb_q),
    .word_q    (word),
    .vld_q     (word_vld),
    .settled_q (settled)
  );

  assign mod_stb = smp;
endmodule

// File: tb/tb_sinc5_decim.sv
`timescale 1ns/1ps
module tb_sinc5_decim;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mod_bit = 1'b0;
  logic        mod_stb;
  logic [23:0] word;
  logic        word_vld;
  logic        settled;

  typedef struct {
    bit    care;
    int    val;
    string tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad   = 0;
  int   cyc   = 0;
  int   nv    = 0;
  int   last_v = -1;
  int   last_s = -1;
  int   held  = 0;
  bit   done  = 1'b0;

  always #2 clk = ~clk;

  sinc5_decim dut (
    .clk      (clk),
    .rst      (rst),
    .mod_bit  (mod_bit),
    .mod_stb  (mod_stb),
    .word     (word),
    .word_vld (word_vld),
    .settled  (settled)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int exp_of(input int k);
    if (k >= 64) return 8388607;
    return (2 * k - 64) * 131072;
  endfunction

  task automatic send_bit(input bit b);
    forever begin
      @(negedge clk);
      if (mod_stb) begin
        mod_bit = b;
        @(posedge clk);
        #1 mod_bit = ~b;   // junk between strobes: R2
        break;
      end
    end
  endtask

  task automatic feed_seg(input int k, input int nw, input string tag);
    for (int w = 0; w < nw; w++) begin
      exp_t it;
      it.care = (w >= 7);
      it.val  = exp_of(k);
      it.tag  = tag;
      q.push_back(it);
      for (int j = 0; j < 64; j++) send_bit(((j * k) % 64) < k);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      nv = 0; last_v = -1; last_s = -1;
    end else begin
      if (mod_stb) begin
        if (last_s >= 0) chk(cyc - last_s == 6, "R1 strobe spacing", cyc - last_s, 6);
        last_s = cyc;
      end
      if (word_vld) begin
        nv++;
        if (last_v >= 0) chk(cyc - last_v == 384, "R3 word spacing", cyc - last_v, 384);
        last_v = cyc;
        held = int'($signed(word));
        chk(settled == (nv >= 5), "R7 settled vs word count", int'(settled), int'(nv >= 5));
        if (q.size() > 0) begin
          exp_t it;
          it = q.pop_front();
          if (it.care) chk(int'($signed(word)) == it.val, it.tag, int'($signed(word)), it.val);
        end
      end else if (last_v >= 0 && cyc == last_v + 200) begin
        chk(int'($signed(word)) == held, "R9 word hold", int'($signed(word)), held);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL R3 watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R8
    chk(word == 24'd0, "R8 word in reset", int'(word), 0);
    chk(!word_vld && !settled && !mod_stb, "R8 flags in reset",
        int'({word_vld, settled, mod_stb}), 0);
    @(posedge clk); #1 rst = 1'b0;

    feed_seg(64, 10, "R5 all ones clip");
    feed_seg(0,  10, "R6 all zeros");
    feed_seg(32, 10, "R4 k=32");
    feed_seg(48, 10, "R4 k=48");
    feed_seg(16, 10, "R4 k=16");
    feed_seg(1,  10, "R4 k=1");

    // R10: reset mid-run
    @(posedge clk); #1 rst = 1'b1;
    q.delete();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!settled, "R10 settled cleared", int'(settled), 0);
    chk(word == 24'd0, "R10 word cleared", int'(word), 0);
    @(posedge clk); #1 rst = 1'b0;
    feed_seg(64, 10, "R5 all ones after reset");
    feed_seg(32, 8,  "R4 k=32 after reset");
    repeat (1200) @(posedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule